// File: doc/BRIEF.md
# Write-only I2C target receiver

This block is the bus front end of a display-controller style peripheral. It sees the two I2C lines through open-drain pads and brings both into the system clock domain with a two-flop synchroniser. On the synchronised levels it detects START and STOP conditions and shifts in bytes on the SCL rising edges. The 7-bit target address is fixed in its upper six bits. The lowest bit comes from a strap input, so two of these parts with different strap levels can share one bus.

When the address matches and the direction bit asks for a write, the block acknowledges the address byte and every data byte that follows. Each data byte goes to downstream logic as a one-cycle valid pulse with the byte beside it. At that point the block holds SCL low for at least two system clocks. It keeps holding SCL for as long as the downstream busy input stays high, so a fast bus master cannot overrun slow downstream logic.

A mismatching address makes the block ignore the rest of the transfer. A read request makes it stay silent until the next START. The block never drives data onto SDA. Its only SDA activity is the acknowledge pull. The system clock must run at least 8 times faster than SCL.

Top module: `i2c_wr_target`

## Requirements
- R1: A START is SDA falling while SCL is high. It begins address reception from any state, so a repeated START inside a transfer restarts address matching.
- R2: An address byte is taken MSB first, as seven address bits and then the direction bit. It matches when the address bits equal 011100 followed by the level of `addr_lsb_strap`. On a match with direction bit 0, `sda_pull_o` is 1 (SDA held low) from the low phase after the eighth clock until the low phase after the ninth clock. So SDA reads low during the whole high period of the ninth clock.
- R3: On an address mismatch the block never asserts `sda_pull_o` or `byte_valid_o` until the next START or STOP.
- R4: On a matching address with direction bit 1 (read), the address is not acknowledged. No later byte is acknowledged or delivered until the next START.
- R5: After an acknowledged write address, every further data byte is acknowledged in the same way as R2.
- R6: After the acknowledge clock of a data byte, `byte_valid_o` is high for exactly one system clock and `byte_data_o` carries that byte, MSB first as received. The pulse starts on the third rising system clock edge after SCL falls at the end of the ninth clock.
- R7: `scl_pull_o` is 1 in the cycle of every `byte_valid_o` pulse and in the cycle after it. It then stays 1 while `busy_i` is high. It returns to 0 on the first rising clock edge at which `busy_i` is low, which is no earlier than the second cycle after the pulse. Downstream logic must raise `busy_i` no later than the cycle after the pulse.
- R8: A STOP (SDA rising while SCL is high) at any point, including in the middle of a byte, returns the block to idle. It clears both pulls on the next clock. Bytes clocked afterwards without a new START are not acknowledged.
- R9: Any number of data bytes may follow one address. Each is delivered in order.
- R10: `sda_pull_o` changes only while the synchronised SCL is low, except when a START or STOP clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_i | input | 1 | SDA level seen at the pad |
| scl_i | input | 1 | SCL level seen at the pad |
| addr_lsb_strap | input | 1 | Level of the address LSB |
| busy_i | input | 1 | Downstream cannot take a byte yet |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| scl_pull_o | output | 1 | Open-drain enable: 1 pulls SCL low |
| byte_valid_o | output | 1 | One-cycle pulse for a received data byte |
| byte_data_o | output | 8 | Last received data byte |

## Verification
The assertions check on every cycle the properties that do not depend on the bus history:
- the valid pulse lasts one cycle and always comes with the SCL hold;
- the hold persists while busy is high;
- a STOP clears both pulls;
- the acknowledge pull moves only while SCL is low;
- an ignored transfer stays quiet.

Only the bench's scenarios can show the behaviour that depends on the whole transfer:
- the address decode against the strap level;
- refusal of read requests;
- restart of address matching by a repeated START;
- a STOP that cuts a byte short;
- the exact delivery cycle and order of the bytes.

The bench compares these against its own model of the bus transaction.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_DATA,
        ST_ACK_D,
        ST_HOLD,
        ST_SKIP
    } rx_state_e;

    typedef struct packed {
        rx_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic [BYTE_W-1:0]  dout;
        logic               sda_pull;
        logic               scl_pull;
        logic               vld;
        logic               first;
    } rx_regs_t;
endpackage

// File: rtl/i2c_pad_sync.sv
module i2c_pad_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad,
    output logic lvl,
    output logic prev
);
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], pad};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign lvl  = chain_q[STAGES-1];
    assign prev = chain_q[STAGES];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic sda_lvl,
    input  logic sda_prev,
    input  logic scl_lvl,
    input  logic scl_prev,
    output logic start,
    output logic stop,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_steady_hi;

    assign scl_steady_hi = scl_lvl && scl_prev;
    assign start    = scl_steady_hi && sda_prev && !sda_lvl;
    assign stop     = scl_steady_hi && !sda_prev && sda_lvl;
    assign scl_rise = scl_lvl && !scl_prev;
    assign scl_fall = !scl_lvl && scl_prev;
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
    import i2c_wr_pkg::*;
#(
    parameter logic [5:0] ADDR_UPPER = 6'b011100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_lvl,
    input  logic              start,
    input  logic              stop,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              strap,
    input  logic              busy,
    output logic              sda_pull,
    output logic              scl_pull,
    output logic              vld,
    output logic [BYTE_W-1:0] dout
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    rx_regs_t r_d, r_q;
    logic     addr_hit;

    assign addr_hit = (r_q.sh[BYTE_W-1:1] == {ADDR_UPPER, strap});

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        unique case (r_q.st)
            ST_ADDR, ST_DATA: begin
                if (scl_rise && r_q.cnt < FULL) begin
                    r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_lvl};
                    r_d.cnt = r_q.cnt + 1'b1;
                end
                if (scl_fall && r_q.cnt == FULL) begin
                    if (r_q.st == ST_DATA) begin
                        r_d.st       = ST_ACK_D;
                        r_d.sda_pull = 1'b1;
                        r_d.dout     = r_q.sh;
                    end else if (!addr_hit) begin
                        r_d.st = ST_SKIP;
                    end else if (r_q.sh[0]) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.st       = ST_ACK_A;
                        r_d.sda_pull = 1'b1;
                    end
                end
            end
            ST_ACK_A: begin
                if (scl_fall) begin
                    r_d.sda_pull = 1'b0;
                    r_d.st       = ST_DATA;
                    r_d.cnt      = '0;
                end
            end
            ST_ACK_D: begin
                if (scl_fall) begin
                    r_d.sda_pull = 1'b0;
                    r_d.scl_pull = 1'b1;
                    r_d.vld      = 1'b1;
                    r_d.first    = 1'b1;
                    r_d.st       = ST_HOLD;
                end
            end
            ST_HOLD: begin
                r_d.first = 1'b0;
                if (!r_q.first && !busy) begin
                    r_d.scl_pull = 1'b0;
                    r_d.st       = ST_DATA;
                    r_d.cnt      = '0;
                end
            end
            default: ;
        endcase
        if (stop) begin
            r_d.st       = ST_IDLE;
            r_d.sda_pull = 1'b0;
            r_d.scl_pull = 1'b0;
        end
        if (start) begin
            r_d.st       = ST_ADDR;
            r_d.cnt      = '0;
            r_d.sda_pull = 1'b0;
            r_d.scl_pull = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, sh: '0, dout: '0,
                     sda_pull: 1'b0, scl_pull: 1'b0, vld: 1'b0, first: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_pull = r_q.sda_pull;
    assign scl_pull = r_q.scl_pull;
    assign vld      = r_q.vld;
    assign dout     = r_q.dout;

    // R6: the byte strobe never lasts longer than one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.vld |=> !r_q.vld);

    // R7: a delivered byte always comes with SCL held low
    a_r7_hold_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.vld |-> r_q.scl_pull);

    // R7: busy keeps the SCL hold in place
    a_r7_busy_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.scl_pull && busy && !start && !stop) |=> r_q.scl_pull);

    // R8: a STOP releases both lines on the next clock
    a_r8_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!r_q.sda_pull && !r_q.scl_pull));

    // R10: the acknowledge pull moves only in the SCL low phase
    a_r10_ack_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.sda_pull) |-> (!scl_lvl || $past(start || stop)));

    // R3: an ignored transfer stays silent
    a_r3_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SKIP) |-> (!r_q.sda_pull && !r_q.vld));

    // R4: idle never drives the bus
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> (!r_q.sda_pull && !r_q.scl_pull));
endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
    import i2c_wr_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ADDR_UPPER  = 6'b011100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_i,
    input  logic              addr_lsb_strap,
    input  logic              busy_i,
    output logic              sda_pull_o,
    output logic              scl_pull_o,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_data_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] pads, lvl, prev;
    logic start, stop, scl_rise, scl_fall;

    assign pads = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        i2c_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pad  (pads[g]),
            .lvl  (lvl[g]),
            .prev (prev[g])
        );
    end

    i2c_cond_detect u_det (
        .sda_lvl (lvl[0]),
        .sda_prev(prev[0]),
        .scl_lvl (lvl[1]),
        .scl_prev(prev[1]),
        .start   (start),
        .stop    (stop),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall)
    );

    i2c_wr_fsm #(.ADDR_UPPER(ADDR_UPPER)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sda_lvl (lvl[0]),
        .scl_lvl (lvl[1]),
        .start   (start),
        .stop    (stop),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .strap   (addr_lsb_strap),
        .busy    (busy_i),
        .sda_pull(sda_pull_o),
        .scl_pull(scl_pull_o),
        .vld     (byte_valid_o),
        .dout    (byte_data_o)
    );
endmodule

// File: tb/i2c_wr_target_bench.sv
module i2c_wr_target_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 5;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_sda = 1'b1;
    logic       m_scl = 1'b1;
    logic       strap = 1'b0;
    logic       busy = 1'b0;
    logic       sda_pull, scl_pull, byte_valid;
    logic [7:0] byte_data;
    logic       sda_line, scl_line;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int due_cyc = -1;
    int busy_len = 0;
    bit ack_win = 1'b0;
    bit done = 1'b0;
    int mst = 0;
    logic [7:0] expq[$];

    assign sda_line = m_sda & ~sda_pull;
    assign scl_line = m_scl & ~scl_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_wr_target u_i2c_wr_target (
        .clk           (clk),
        .rst_n         (rst_n),
        .sda_i         (sda_line),
        .scl_i         (scl_line),
        .addr_lsb_strap(strap),
        .busy_i        (busy),
        .sda_pull_o    (sda_pull),
        .scl_pull_o    (scl_pull),
        .byte_valid_o  (byte_valid),
        .byte_data_o   (byte_data)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    // Reference model: per-clock strobe timing, byte order, quiet SDA outside ack
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (byte_valid !== (cyc == due_cyc))
                check(1'b0, "R6 strobe timing", byte_valid, cyc == due_cyc);
            if (byte_valid) begin
                if (expq.size() == 0) check(1'b0, "R9 unexpected byte", byte_data, 0);
                else begin
                    logic [7:0] e;
                    e = expq.pop_front();
                    check(byte_data == e, "R6 R9 byte data", byte_data, e);
                    check(scl_pull == 1'b1, "R7 hold with strobe", scl_pull, 1);
                end
            end
            if (sda_pull && !ack_win) check(1'b0, "R3 R8 stray SDA pull", 1, 0);
        end
    end

    // Downstream busy responder
    initial begin
        forever begin
            @(negedge clk);
            if (byte_valid && busy_len > 0) begin
                busy = 1'b1;
                repeat (busy_len) begin
                    @(negedge clk);
                    check(scl_pull == 1'b1, "R7 hold while busy", scl_pull, 1);
                end
                busy = 1'b0;
                @(negedge clk);
                check(scl_pull == 1'b0, "R7 release after busy", scl_pull, 0);
            end
        end
    end

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wait_scl_high(); wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
        mst = 1;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wait_scl_high(); wq();
        m_sda = 1'b1; wq();
        mst = 0;
    endtask

    task automatic send_bit(input bit b);
        m_sda = b; wq();
        m_scl = 1'b1; wait_scl_high(); wq(); wq();
        m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input string req);
        bit exp_ack, got_ack, deliver;
        deliver = (mst == 2);
        if (mst == 1) begin
            exp_ack = (b[7:2] == 6'b011100) && (b[1] == strap) && !b[0];
            mst = exp_ack ? 2 : 0;
        end else begin
            exp_ack = deliver;
        end
        for (int i = 7; i >= 0; i--) begin
            send_bit(b[i]);
            if (i != 0) wq();
        end
        ack_win = 1'b1;
        wq();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wait_scl_high(); wq();
        got_ack = !sda_line;
        check(got_ack == exp_ack, req, got_ack, exp_ack);
        wq();
        got_ack = !sda_line;
        check(got_ack == exp_ack, {req, " ack held"}, got_ack, exp_ack);
        m_scl = 1'b0;
        if (deliver) begin
            due_cyc = cyc + 3;
            expq.push_back(b);
        end
        wq();
        ack_win = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({sda_pull, scl_pull, byte_valid, byte_data} == 11'd0, "R1 reset state",
              {sda_pull, scl_pull, byte_valid, byte_data}, 0);

        // R2 R5 R6: plain write, strap 0 -> address 0x38
        bus_start();
        send_byte(8'h70, "R2 address ack");
        send_byte(8'hA5, "R5 data ack");
        send_byte(8'h00, "R5 data ack");
        send_byte(8'hFF, "R5 data ack");
        bus_stop();

        // R7: downstream busy stretches SCL
        busy_len = 20;
        bus_start();
        send_byte(8'h70, "R2 address ack");
        send_byte(8'h3C, "R7 busy byte ack");
        send_byte(8'hC3, "R7 busy byte ack");
        bus_stop();
        busy_len = 0;

        // R3: mismatching LSB and mismatching upper bits
        bus_start();
        send_byte(8'h72, "R3 mismatch no ack");
        send_byte(8'h70, "R3 ignored byte");
        send_byte(8'h55, "R3 ignored byte");
        bus_stop();
        bus_start();
        send_byte(8'hF0, "R3 upper mismatch");
        send_byte(8'h12, "R3 ignored byte");
        bus_stop();

        // R2: strap 1 -> address 0x39
        strap = 1'b1;
        bus_start();
        send_byte(8'h70, "R3 strap mismatch");
        bus_stop();
        bus_start();
        send_byte(8'h72, "R2 strap address ack");
        send_byte(8'h96, "R5 strap data ack");
        bus_stop();
        strap = 1'b0;

        // R4: read request is refused
        bus_start();
        send_byte(8'h71, "R4 read no ack");
        send_byte(8'h44, "R4 no ack after read");
        bus_stop();

        // R1: repeated START restarts matching
        bus_start();
        send_byte(8'h70, "R2 address ack");
        send_byte(8'h11, "R5 data ack");
        bus_start();
        send_byte(8'h72, "R1 restart mismatch");
        send_byte(8'h99, "R1 ignored after restart");
        bus_start();
        send_byte(8'h70, "R1 restart match");
        send_byte(8'h22, "R1 data after restart");
        bus_stop();

        // R8: STOP in the middle of a byte
        bus_start();
        send_byte(8'h70, "R2 address ack");
        send_bit(1'b0); wq();
        send_bit(1'b1); wq();
        send_bit(1'b1); wq();
        send_bit(1'b1); wq();
        bus_stop();
        repeat (2) @(negedge clk);
        check(sda_pull == 1'b0 && scl_pull == 1'b0, "R8 released after stop", sda_pull, 0);
        send_byte(8'h70, "R8 no ack without start");
        bus_stop();

        // R9: a long transfer
        bus_start();
        send_byte(8'h70, "R2 address ack");
        for (int i = 0; i < 20; i++) send_byte(8'(i * 13 + 7), "R9 long transfer ack");
        bus_stop();

        repeat (20) @(negedge clk);
        check(expq.size() == 0, "R9 all bytes delivered", expq.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > WATCHDOG);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "R1 watchdog expired", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule